// File: doc/BRIEF.md
# Bad-Block Marker Locator and Swapper

This block works out where the factory bad-block marker ends up inside a flash page whose user data is interleaved with per-chunk ECC parity. From the page data size and the spare size it computes the number of 512-byte chunks, the ECC strength the spare area can carry, and the marker's byte and bit position as seen in the data buffer. It then swaps that marker byte with byte 0 of the spare buffer through a byte-wide memory port.

The marker seen through the ECC layout is in general not byte aligned. The byte exchanged with the spare buffer is therefore pieced together from two neighbouring data bytes at any bit offset, and only the bits that belong to it are written back. Swapping twice restores the original contents, so the same operation serves both before programming a page and after reading one. A geometry that cannot be laid out is reported with an error flag instead of a swap.

The two divisions share one multi-cycle restoring divider. The block stays busy from an accepted start until its one-cycle done pulse.

Top module: `bbm_swapper`

## Requirements
- R1: Chunk count is page_bytes / 512. ecc_level is ((spare_bytes - 10) * 8) / (13 * chunk count), rounded down to an even value.
- R2: With bit offset P = page_bytes*8 - 80, chunk width T = 4096 + 13*ecc_level and chunk index K = P / T, the marker offset is F = P - K*13*ecc_level. mark_byte is F >> 3 and mark_bit is F[2:0]. Both are valid when done is high.
- R3: geo_err is raised together with done, and no memory write is issued, when spare_bytes < 10, when page_bytes < 512, or when P - K*T exceeds 4096.
- R4: Spare byte 0 receives the low 8 bits of ({data[b+1], data[b]} >> bit), where b = mark_byte and bit = mark_bit.
- R5: data[b] bits at and above bit are replaced by the old spare byte 0 shifted left by bit, and its lower bits are kept. data[b+1] bits below bit are replaced by the old spare byte shifted right by (8 - bit), and its upper bits are kept.
- R6: When mark_bit is 0, no write is issued to data[b+1] and its value is unchanged.
- R7: Two runs with the same geometry leave data[b], data[b+1] and spare byte 0 as they were before the first run.
- R8: start is ignored while busy is high. A start that arrives during a run produces no further done and does not change that run's result.
- R9: After reset, busy, done, geo_err and mem_en are 0. done is high for exactly one cycle per accepted start, and busy stays high from the cycle after the start until done.
- R10: Memory accesses happen only while busy. mem_spare=1 selects the spare buffer and then mem_addr is always 0. mem_rdata is taken one cycle after a read request (mem_en=1, mem_we=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled when idle |
| page_bytes | input | 16 | Page data size in bytes |
| spare_bytes | input | 12 | Spare area size in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| geo_err | output | 1 | Geometry invalid, valid with done |
| ecc_level | output | 16 | Derived ECC strength |
| mark_byte | output | 16 | Marker byte offset in the data buffer |
| mark_bit | output | 3 | Marker bit offset within that byte |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_spare | output | 1 | 1 = spare buffer, 0 = data buffer |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the request |

## Verification
The hardest case to reach is a chunk remainder that exceeds the data bits. This only happens when the marker falls in chunk 0 while the page is longer than one chunk's data, which needs an unusually large spare area. The stimulus uses a 1024-byte page with an 1100-byte spare to get there. Unaligned swaps need ECC strengths whose parity total, multiplied by the chunk index, is not a multiple of eight. The geometries 2048/24 and 2048/112 give bit offsets 2 and 6, and 2048/64 gives the aligned case. A second start pulse issued in the middle of a running swap checks that it is dropped.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int CHUNK_DATA_BYTES = 512;
    localparam int META_BYTES       = 10;
    localparam int PARITY_PER_LEVEL = 13;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DIV_LVL,
        S_WAIT_LVL,
        S_DIV_POS,
        S_WAIT_POS,
        S_CHECK,
        S_RD_LO,
        S_RD_HI,
        S_RD_SP,
        S_CAPT,
        S_WR_LO,
        S_WR_HI,
        S_WR_SP,
        S_FIN
    } swap_state_t;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] spare;
    } byte_trio_t;

endpackage

// File: rtl/bbm_divider.sv
module bbm_divider #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  part;
    logic [W-1:0]  q;
    logic [W-1:0]  num_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;
    logic          fits;

    always_comb begin
        trial = {part, q[W-1]};
        fits  = trial >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part  <= '0;
            q     <= '0;
            num_q <= '0;
            den_q <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                part  <= '0;
                q     <= num;
                num_q <= num;
                den_q <= den;
                cnt   <= CW'(W);
                run   <= 1'b1;
            end else if (run) begin
                part <= fits ? W'(trial - {1'b0, den_q}) : W'(trial);
                q    <= {q[W-2:0], fits};
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = q;
    assign rem = part;

    a_r1_div_exact: assert property (@(posedge clk) disable iff (rst)
        done |-> ((2*W)'(quo) * (2*W)'(den_q) + (2*W)'(rem) == (2*W)'(num_q)));

    a_r1_div_rem: assert property (@(posedge clk) disable iff (rst)
        (done && den_q != '0) |-> (rem < den_q));

endmodule

// File: rtl/bbm_splice.sv
module bbm_splice
    import bbm_pkg::*;
(
    input  byte_trio_t  old_bytes,
    input  logic [2:0]  bit_ofs,
    output logic [7:0]  marker,
    output logic [7:0]  lo_new,
    output logic [7:0]  hi_new
);
    logic [15:0] pair;
    logic [15:0] ins;
    logic [15:0] keep;
    logic [15:0] merged;
    logic [15:0] shifted;

    always_comb begin
        pair    = {old_bytes.hi, old_bytes.lo};
        shifted = pair >> bit_ofs;
        marker  = shifted[7:0];
        ins     = {8'h00, old_bytes.spare} << bit_ofs;
        keep    = ~(16'h00FF << bit_ofs);
        merged  = (pair & keep) | ins;
        lo_new  = merged[7:0];
        hi_new  = merged[15:8];
    end

endmodule

// File: rtl/bbm_swapper.sv
module bbm_swapper
    import bbm_pkg::*;
#(
    parameter int PAGE_W      = 16,
    parameter int SPARE_W     = 12,
    parameter int CHUNK_BYTES = CHUNK_DATA_BYTES,
    parameter int META_B      = META_BYTES,
    parameter int PARITY_BITS = PARITY_PER_LEVEL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_bytes,
    input  logic [SPARE_W-1:0] spare_bytes,
    output logic              busy,
    output logic              done,
    output logic              geo_err,
    output logic [PAGE_W-1:0] ecc_level,
    output logic [PAGE_W-1:0] mark_byte,
    output logic [2:0]        mark_bit,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_spare,
    output logic [PAGE_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int DW         = PAGE_W + 4;
    localparam int CHUNK_SH   = $clog2(CHUNK_BYTES);
    localparam int CHUNK_BITS = CHUNK_BYTES * 8;
    localparam int META_BITS  = META_B * 8;

    swap_state_t       state;
    logic [PAGE_W-1:0] page_q;
    logic [SPARE_W-1:0] spare_q;
    logic [DW-1:0]     level_q;
    logic [DW-1:0]     idx_q;
    logic [DW-1:0]     rem_q;
    logic [PAGE_W-1:0] byte_q;
    logic [2:0]        bit_q;
    logic              err_q;
    byte_trio_t        trio_q;

    logic [DW-1:0] chunks;
    logic [DW-1:0] bit_start;
    logic [DW-1:0] num_lvl;
    logic [DW-1:0] den_lvl;
    logic [DW-1:0] den_pos;
    logic [DW-1:0] parity_skip;
    logic [DW-1:0] final_ofs;
    logic          early_bad;

    logic          div_start;
    logic [DW-1:0] div_num;
    logic [DW-1:0] div_den;
    logic          div_done;
    logic [DW-1:0] div_quo;
    logic [DW-1:0] div_rem;

    logic [7:0] marker;
    logic [7:0] lo_new;
    logic [7:0] hi_new;

    // Geometry arithmetic
    always_comb begin
        chunks      = DW'(page_q >> CHUNK_SH);
        bit_start   = (DW'(page_q) << 3) - DW'(META_BITS);
        num_lvl     = (DW'(spare_q) - DW'(META_B)) << 3;
        den_lvl     = chunks * DW'(PARITY_BITS);
        den_pos     = DW'(CHUNK_BITS) + DW'(PARITY_BITS) * level_q;
        parity_skip = idx_q * level_q * DW'(PARITY_BITS);
        final_ofs   = bit_start - parity_skip;
        early_bad   = (spare_q < SPARE_W'(META_B)) || (chunks == '0);
    end

    always_comb begin
        div_start = (state == S_DIV_LVL) || (state == S_DIV_POS);
        div_num   = (state == S_DIV_POS) ? bit_start : num_lvl;
        div_den   = (state == S_DIV_POS) ? den_pos : den_lvl;
    end

    bbm_divider #(.W(DW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    bbm_splice u_splice (
        .old_bytes (trio_q),
        .bit_ofs   (bit_q),
        .marker    (marker),
        .lo_new    (lo_new),
        .hi_new    (hi_new)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            page_q  <= '0;
            spare_q <= '0;
            level_q <= '0;
            idx_q   <= '0;
            rem_q   <= '0;
            byte_q  <= '0;
            bit_q   <= '0;
            err_q   <= 1'b0;
            trio_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        page_q  <= page_bytes;
                        spare_q <= spare_bytes;
                        err_q   <= 1'b0;
                        state   <= S_DIV_LVL;
                    end
                end
                S_DIV_LVL: begin
                    if (early_bad) begin
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        state <= S_WAIT_LVL;
                    end
                end
                S_WAIT_LVL: begin
                    if (div_done) begin
                        level_q <= {div_quo[DW-1:1], 1'b0};
                        state   <= S_DIV_POS;
                    end
                end
                S_DIV_POS: state <= S_WAIT_POS;
                S_WAIT_POS: begin
                    if (div_done) begin
                        idx_q <= div_quo;
                        rem_q <= div_rem;
                        state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (rem_q > DW'(CHUNK_BITS)) begin
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        byte_q <= PAGE_W'(final_ofs >> 3);
                        bit_q  <= final_ofs[2:0];
                        state  <= S_RD_LO;
                    end
                end
                S_RD_LO: state <= S_RD_HI;
                S_RD_HI: begin
                    trio_q.lo <= mem_rdata;
                    state     <= S_RD_SP;
                end
                S_RD_SP: begin
                    trio_q.hi <= mem_rdata;
                    state     <= S_CAPT;
                end
                S_CAPT: begin
                    trio_q.spare <= mem_rdata;
                    state        <= S_WR_LO;
                end
                S_WR_LO: state <= (bit_q != 3'd0) ? S_WR_HI : S_WR_SP;
                S_WR_HI: state <= S_WR_SP;
                S_WR_SP: state <= S_FIN;
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_spare = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_RD_LO: begin
                mem_en   = 1'b1;
                mem_addr = byte_q;
            end
            S_RD_HI: begin
                mem_en   = 1'b1;
                mem_addr = byte_q + 1'b1;
            end
            S_RD_SP: begin
                mem_en    = 1'b1;
                mem_spare = 1'b1;
            end
            S_WR_LO: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_q;
                mem_wdata = lo_new;
            end
            S_WR_HI: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_q + 1'b1;
                mem_wdata = hi_new;
            end
            S_WR_SP: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_spare = 1'b1;
                mem_wdata = marker;
            end
            default: ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign done      = (state == S_FIN);
    assign geo_err   = done && err_q;
    assign ecc_level = PAGE_W'(level_q);
    assign mark_byte = byte_q;
    assign mark_bit  = bit_q;

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    a_r10_mem_busy: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);

    a_r10_spare_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_spare) |-> (mem_addr == '0));

    a_r3_err_no_write: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !(mem_en && mem_we));

    a_r6_aligned_no_hi: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && !mem_spare && mem_addr == mark_byte + 1'b1) |-> (mark_bit != 3'd0));

    a_r1_even_level: assert property (@(posedge clk) disable iff (rst)
        (done && !geo_err) |-> !ecc_level[0]);

    a_r8_geometry_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(page_q) && $stable(spare_q)));

endmodule

// File: tb/sim_bbm_swapper.sv
module sim_bbm_swapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] page_bytes = '0;
    logic [11:0] spare_bytes = '0;
    logic        busy, done, geo_err;
    logic [15:0] ecc_level, mark_byte;
    logic [2:0]  mark_bit;
    logic        mem_en, mem_we, mem_spare;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    always #5 clk = ~clk;

    bbm_swapper u0 (
        .clk(clk), .rst(rst), .start(start),
        .page_bytes(page_bytes), .spare_bytes(spare_bytes),
        .busy(busy), .done(done), .geo_err(geo_err),
        .ecc_level(ecc_level), .mark_byte(mark_byte), .mark_bit(mark_bit),
        .mem_en(mem_en), .mem_we(mem_we), .mem_spare(mem_spare),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int done_cycles = 0;
    bit finished = 1'b0;

    logic [7:0] dmem [int];
    logic [7:0] smem [int];
    int         wlog [$];
    int         wtotal = 0;

    typedef struct {
        bit         err;
        int         level;
        int         b;
        int         bt;
        logic [7:0] exp_lo, exp_hi, exp_sp, pre_hi;
    } exp_t;

    exp_t sb [$];

    function automatic logic [7:0] rd_d(int a);
        if (dmem.exists(a)) return dmem[a];
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] rd_s(int a);
        if (smem.exists(a)) return smem[a];
        return 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Memory responder: one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (mem_spare) smem[int'(mem_addr)] = mem_wdata;
                else begin
                    dmem[int'(mem_addr)] = mem_wdata;
                    wlog.push_back(int'(mem_addr));
                end
                wtotal++;
            end else begin
                mem_rdata <= mem_spare ? rd_s(int'(mem_addr)) : rd_d(int'(mem_addr));
            end
        end
    end

    // Reference geometry from the requirements
    task automatic ref_geom(input int page, input int spare, output bit err,
                            output int level, output int b, output int bt);
        int chunks, off, tot, idx, rem, fin;
        err = 0; level = 0; b = 0; bt = 0;
        chunks = page / 512;
        if (spare < 10 || chunks == 0) begin err = 1; return; end
        level = ((spare - 10) * 8) / (13 * chunks);
        level = level & ~1;
        off = page * 8 - 80;
        tot = 4096 + 13 * level;
        idx = off / tot;
        rem = off - idx * tot;
        if (rem > 4096) begin err = 1; return; end
        fin = off - idx * 13 * level;
        b = fin >> 3;
        bt = fin & 7;
    endtask

    // Driver: push expectation, pulse start
    task automatic drive(input int page, input int spare);
        exp_t e;
        logic [7:0] lo, hi, sp;
        ref_geom(page, spare, e.err, e.level, e.b, e.bt);
        lo = rd_d(e.b); hi = rd_d(e.b + 1); sp = rd_s(0);
        e.pre_hi = hi;
        for (int i = 0; i < 8; i++) begin
            int p;
            p = e.bt + i;
            e.exp_sp[i] = (p < 8) ? lo[p] : hi[p - 8];
        end
        e.exp_lo = lo; e.exp_hi = hi;
        for (int j = 0; j < 8; j++) begin
            if (j >= e.bt) e.exp_lo[j] = sp[j - e.bt];
            if (j < e.bt)  e.exp_hi[j] = sp[8 - e.bt + j];
        end
        if (e.err) begin e.exp_lo = lo; e.exp_hi = hi; e.exp_sp = sp; end
        sb.push_back(e);
        wlog.delete();
        @(negedge clk);
        page_bytes = 16'(page); spare_bytes = 12'(spare); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            done_cycles++;
            if (sb.size() == 0) begin
                chk(0, "R8", "unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                chk(geo_err == e.err, "R3", "geo_err", geo_err, e.err);
                if (e.err) begin
                    chk(wlog.size() == 0, "R3", "writes on error", wlog.size(), 0);
                    chk(rd_s(0) == e.exp_sp, "R3", "spare untouched", rd_s(0), e.exp_sp);
                end else begin
                    chk(int'(ecc_level) == e.level, "R1", "ecc_level", ecc_level, e.level);
                    chk(int'(mark_byte) == e.b, "R2", "mark_byte", mark_byte, e.b);
                    chk(int'(mark_bit) == e.bt, "R2", "mark_bit", mark_bit, e.bt);
                    chk(rd_s(0) == e.exp_sp, "R4", "spare byte 0", rd_s(0), e.exp_sp);
                    chk(rd_d(e.b) == e.exp_lo, "R5", "data[b]", rd_d(e.b), e.exp_lo);
                    chk(rd_d(e.b + 1) == e.exp_hi, "R5", "data[b+1]", rd_d(e.b + 1), e.exp_hi);
                    if (e.bt == 0) begin
                        int hits;
                        hits = 0;
                        foreach (wlog[i]) if (wlog[i] == e.b + 1) hits++;
                        chk(hits == 0, "R6", "writes to data[b+1]", hits, 0);
                        chk(rd_d(e.b + 1) == e.pre_hi, "R6", "data[b+1] kept", rd_d(e.b + 1), e.pre_hi);
                    end
                end
            end
        end
    end

    task automatic run_one(input int page, input int spare);
        int d0;
        d0 = done_cycles;
        drive(page, spare);
        wait_idle();
        chk(done_cycles == d0 + 1, "R9", "done cycles per run", done_cycles - d0, 1);
    endtask

    initial begin
        int b7, bt7, lv7;
        bit e7;
        logic [7:0] s_lo, s_hi, s_sp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R9", "reset busy/done", {busy, done}, 0);
        chk(geo_err == 0 && mem_en == 0, "R9", "reset err/mem_en", {geo_err, mem_en}, 0);

        dmem[1999] = 8'h3C; dmem[2000] = 8'hC3; smem[0] = 8'h00;
        run_one(2048, 64);     // aligned marker, R6
        dmem[2028] = 8'hF0; dmem[2029] = 8'h0F; smem[0] = 8'h5A;
        run_one(2048, 24);     // bit offset 2
        run_one(4096, 224);

        // R7: two identical runs restore the buffers
        ref_geom(2048, 112, e7, lv7, b7, bt7);
        dmem[b7] = 8'h96; dmem[b7 + 1] = 8'h69; smem[0] = 8'hE1;
        s_lo = rd_d(b7); s_hi = rd_d(b7 + 1); s_sp = rd_s(0);
        run_one(2048, 112);    // bit offset 6
        run_one(2048, 112);
        chk(rd_d(b7) == s_lo, "R7", "data[b] restored", rd_d(b7), s_lo);
        chk(rd_d(b7 + 1) == s_hi, "R7", "data[b+1] restored", rd_d(b7 + 1), s_hi);
        chk(rd_s(0) == s_sp, "R7", "spare restored", rd_s(0), s_sp);

        // R3 error geometries
        run_one(2048, 8);
        run_one(256, 64);
        run_one(1024, 1100);

        // R8: start during busy is dropped
        begin
            int d0;
            d0 = done_cycles;
            drive(4096, 128);
            repeat (5) @(negedge clk);
            page_bytes = 16'd2048; spare_bytes = 12'd24; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_idle();
            repeat (60) @(negedge clk);
            chk(done_cycles == d0 + 1, "R8", "done count with extra start", done_cycles - d0, 1);
            chk(busy == 0, "R8", "idle after run", busy, 0);
        end

        run_one(512, 16);
        chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule